// File: doc/BRIEF.md
# Single-Stream DMA Transfer Engine

This block moves a programmed number of data items from a source address to a destination address. Items pass through a small internal FIFO on the way. The stream has one address register for the peripheral side and two memory pointers. A 2-bit direction code decides which of these is read and which is written. The FIFO fills from the source until its level reaches a programmable threshold, and then it empties completely into the destination before reading starts again. The fill phase also ends early when no reads remain or when the stream is stopping.

Software programs the engine through a small write-only configuration port. Writing the control word with its enable bit set starts a transfer. The same write is checked first for a legal direction, a legal item size, aligned addresses and a non-zero count. A transfer ends in one of three ways:
- the item count runs out;
- the peripheral signals end of transfer while it owns flow control;
- software writes the control word with enable clear.

In the last two cases the FIFO is flushed before the engine goes idle. In double-buffer mode the item count is reloaded each time it runs out, and the memory side swaps to the other pointer.

Both bus master ports use valid/ready handshakes. A read completes in the cycle where `rd_valid` and `rd_ready` are both high, and `rd_data` is taken in that same cycle.

Top module: `dma_stream_engine`

## Requirements
- R1: The direction code `ctrl[2:1]` routes the data. 00 reads the peripheral address and writes through memory pointer 0. 01 reads through memory pointer 0 and writes the peripheral address. 10 reads the peripheral address register and writes through memory pointer 0, with no peripheral handshake. Data reaches the destination unchanged and in read order.
- R2: A start is refused when any of these holds: direction 11, size code 11, count zero, or a misaligned peripheral, memory-0 or (in double-buffer mode) memory-1 address. A refused start sets `cfg_err` and leaves `busy` low. A successful start clears `cfg_err`.
- R3: `items_left` drops by exactly one for each completed write. When it reaches zero outside double-buffer mode, `busy` falls and `done` is set.
- R4: For directions 00 and 01, no read is issued without a pending request, and each `preq` pulse allows exactly one read.
- R5: For direction 10, reads run back-to-back with `preq` held low.
- R6: Writes start only after the FIFO level reaches the threshold `ctrl[11:9]`, or after the last read. A value of 0 or a value above the depth means the full depth. The FIFO drains to empty before the next read.
- R7: The size field `ctrl[4:3]` selects byte (00), half-word (01) or word (10). The peripheral-side address advances by 1, 2 or 4 bytes per item when `ctrl[5]` is set. The memory-side address advances the same way when `ctrl[6]` is set. An address with its increment bit clear stays fixed. Any 32-bit address, up to 0xFFFFFFFF, can be used.
- R8: When `ctrl[8]` (peripheral flow control) is set, a `peot` pulse stops further reads, flushes the FIFO and then sets `done`. When `ctrl[8]` is clear, `peot` has no effect.
- R9: Writing the control word with bit 0 clear during a transfer stops further reads. Every item already read is still written before `busy` falls and `done` is set.
- R10: When `ctrl[7]` is set, every time `items_left` runs out it is reloaded, `mem_sel` toggles, and the memory-side address restarts at the base of the other pointer.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_addr` stays unchanged.
- R12: After reset, `busy`, `done`, `cfg_err`, `rd_valid` and `wr_valid` are all low.

Configuration selects (`cfg_sel`): 0 control, 1 item count, 2 peripheral address, 3 memory pointer 0, 4 memory pointer 1. Control bit 0 is enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| preq | input | 1 | Peripheral transfer request |
| peot | input | 1 | Peripheral end-of-transfer |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read item size code |
| rd_ready | input | 1 | Read accepted; data valid this cycle |
| rd_data | input | DW | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write item size code |
| wr_data | output | DW | Write data |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete, sticky until next start |
| cfg_err | output | 1 | Refused start |
| mem_sel | output | 1 | Memory pointer currently in use |
| items_left | output | CW | Items remaining in current buffer |

## Verification
The bench uses the default parameters: a FIFO depth of 4, 32-bit addresses and data, and a 16-bit counter. With a depth of 4, every threshold code from 1 to 4 is reachable, and codes 0 and above 4 fall back to the full depth. This lets short transfers of 3 to 7 items show partial final chunks and drains cut short by the end of reads. The 32-bit width lets vectors start near 0xFFFFFFF0, so the highest addresses of the space are covered. The 16-bit count is large enough for long transfers that are cut off by `peot` or by disabling.

// File: rtl/dma_stream_engine.sv
module dma_stream_engine #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          preq,
  input  logic          peot,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          busy,
  output logic          done,
  output logic          cfg_err,
  output logic          mem_sel,
  output logic [CW-1:0] items_left
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [AW-1:0] par_q, m0_q, m1_q, src_q, dst_q;
  logic [CW-1:0] len_q, cnt_q, rdl_q;
  logic [1:0]    dir_q, size_q;
  logic          pinc_q, minc_q, dbuf_q, pflow_q;
  logic [FW-1:0] thr_q, fill_q;
  logic [PW-1:0] wp_q, rp_q;
  logic          busy_q, done_q, err_q, stop_q, drain_q, req_q, msel_q;
  logic [DW-1:0] fifo [DEPTH];

  function automatic logic misal(input logic [AW-1:0] a, input logic [1:0] s);
    return (s == 2'd1 && a[0]) || (s == 2'd2 && a[1:0] != 2'b00) || s == 2'd3;
  endfunction

  logic [1:0] w_dir, w_size;
  logic [2:0] w_thr;
  assign w_dir  = cfg_wdata[2:1];
  assign w_size = cfg_wdata[4:3];
  assign w_thr  = cfg_wdata[11:9];

  logic ctl_wr, start_try, bad, p_src, w_psrc, sinc, dinc;
  assign ctl_wr    = cfg_we && cfg_sel == 3'd0;
  assign start_try = ctl_wr && cfg_wdata[0] && !busy_q;
  assign bad = w_dir == 2'd3 || misal(par_q, w_size) || misal(m0_q, w_size) ||
               (cfg_wdata[7] && misal(m1_q, w_size)) || len_q == '0;
  assign p_src  = dir_q != 2'd1;
  assign w_psrc = w_dir != 2'd1;
  assign sinc   = p_src ? pinc_q : minc_q;
  assign dinc   = p_src ? minc_q : pinc_q;

  logic [AW-1:0] step;
  assign step = AW'(1) << size_q;

  logic rhs, whs, stop_nx, finish, swap, to_drain;
  logic [FW-1:0] fill_nx;
  logic [CW-1:0] rdl_nx, cnt_nx;
  assign rd_valid = busy_q && !drain_q && !stop_q && rdl_q != '0 &&
                    fill_q < FW'(DEPTH) && (dir_q == 2'd2 || req_q);
  assign wr_valid = busy_q && drain_q && fill_q != '0;
  assign rhs      = rd_valid && rd_ready;
  assign whs      = wr_valid && wr_ready;
  assign fill_nx  = fill_q + FW'(rhs) - FW'(whs);
  assign rdl_nx   = rdl_q - CW'(rhs);
  assign cnt_nx   = cnt_q - CW'(whs);
  assign stop_nx  = stop_q || (busy_q && ((ctl_wr && !cfg_wdata[0]) || (peot && pflow_q)));
  assign finish   = busy_q && ((whs && cnt_nx == '0 && !dbuf_q) || (stop_nx && fill_nx == '0));
  assign swap     = busy_q && whs && cnt_nx == '0 && dbuf_q && !stop_nx;
  assign to_drain = fill_nx != '0 && (fill_nx >= thr_q || rdl_nx == '0 || stop_nx);

  assign rd_addr    = src_q;
  assign wr_addr    = dst_q;
  assign rd_size    = size_q;
  assign wr_size    = size_q;
  assign wr_data    = fifo[rp_q];
  assign busy       = busy_q;
  assign done       = done_q;
  assign cfg_err    = err_q;
  assign mem_sel    = msel_q;
  assign items_left = cnt_q;

  always_ff @(posedge clk)
    if (rhs) fifo[wp_q] <= rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= '0; m0_q <= '0; m1_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; cnt_q <= '0; rdl_q <= '0;
      dir_q <= '0; size_q <= '0; pinc_q <= 1'b0; minc_q <= 1'b0;
      dbuf_q <= 1'b0; pflow_q <= 1'b0; thr_q <= '0; fill_q <= '0;
      wp_q <= '0; rp_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; stop_q <= 1'b0;
      drain_q <= 1'b0; req_q <= 1'b0; msel_q <= 1'b0;
    end else begin
      req_q <= (req_q && !rhs) || preq;
      if (cfg_we)
        case (cfg_sel)
          3'd1: len_q <= cfg_wdata[CW-1:0];
          3'd2: par_q <= AW'(cfg_wdata);
          3'd3: m0_q  <= AW'(cfg_wdata);
          3'd4: m1_q  <= AW'(cfg_wdata);
          default: ;
        endcase
      if (rhs) begin
        wp_q  <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
        src_q <= src_q + (sinc ? step : '0);
      end
      if (whs) begin
        rp_q  <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
        dst_q <= dst_q + (dinc ? step : '0);
      end
      fill_q <= fill_nx;
      rdl_q  <= rdl_nx;
      cnt_q  <= cnt_nx;
      stop_q <= stop_nx;
      if (!drain_q) drain_q <= to_drain;
      else if (fill_nx == '0) drain_q <= 1'b0;
      if (swap) begin
        msel_q  <= !msel_q;
        cnt_q   <= len_q;
        rdl_q   <= len_q;
        drain_q <= 1'b0;
        if (p_src) dst_q <= msel_q ? m0_q : m1_q;
        else       src_q <= msel_q ? m0_q : m1_q;
      end
      if (finish) begin
        busy_q <= 1'b0; done_q <= 1'b1; stop_q <= 1'b0; drain_q <= 1'b0;
      end
      if (start_try) begin
        if (bad) err_q <= 1'b1;
        else begin
          err_q <= 1'b0; done_q <= 1'b0; busy_q <= 1'b1;
          dir_q <= w_dir; size_q <= w_size;
          pinc_q <= cfg_wdata[5]; minc_q <= cfg_wdata[6];
          dbuf_q <= cfg_wdata[7]; pflow_q <= cfg_wdata[8];
          thr_q <= (w_thr == 3'd0 || 32'(w_thr) > DEPTH) ? FW'(DEPTH) : FW'(w_thr);
          src_q <= w_psrc ? par_q : m0_q;
          dst_q <= w_psrc ? m0_q : par_q;
          cnt_q <= len_q; rdl_q <= len_q;
          fill_q <= '0; wp_q <= '0; rp_q <= '0;
          stop_q <= 1'b0; drain_q <= 1'b0; msel_q <= 1'b0; req_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma_stream_chk.sv
module dma_stream_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int FW    = 3
)(
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [2:0]    cfg_lo,
  input logic          busy,
  input logic          done,
  input logic          cfg_err,
  input logic [CW-1:0] items_left,
  input logic          rd_valid,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [1:0]    wr_size,
  input logic [FW-1:0] fill_q
);
  // R2
  bad_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel == 3'd0 && cfg_lo == 3'b111 && !busy |=> !busy && cfg_err);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && items_left > CW'(1) |=> items_left == $past(items_left) - CW'(1));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

  // R7
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !((wr_size == 2'd1 && wr_addr[0]) || (wr_size == 2'd2 && wr_addr[1:0] != 2'b00)));

  // R3
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy));

  // R6
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(DEPTH));
endmodule

bind dma_stream_engine dma_stream_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lo(cfg_wdata[2:0]),
  .busy(busy), .done(done), .cfg_err(cfg_err), .items_left(items_left),
  .rd_valid(rd_valid), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_size(wr_size), .fill_q(fill_q)
);

// File: tb/sim_dma_stream_engine.sv
module sim_dma_stream_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cfg_we = 1'b0, preq = 1'b0, peot = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic rd_valid, rd_ready, wr_valid, wr_ready, busy, done, cfg_err, mem_sel;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [1:0] rd_size, wr_size;
  logic [15:0] items_left;

  logic stall_en = 1'b0;
  logic [1:0] ph = '0;
  always @(posedge clk) begin #1; ph = ph + 2'd1; end
  assign wr_ready = !(stall_en && ph == 2'd0);
  assign rd_ready = 1'b1;
  assign rd_data  = rd_addr * 32'd3 + 32'h11;

  dma_stream_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .preq(preq), .peot(peot),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_size(rd_size), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .cfg_err(cfg_err), .mem_sel(mem_sel), .items_left(items_left)
  );

  int nchk = 0, nfail = 0, nev = 0, nrd = 0, nwr = 0;
  logic ev [256];
  logic [31:0] wa [256];
  logic [31:0] wd [256];

  always @(negedge clk) if (rst_n) begin
    if (rd_valid && rd_ready) begin
      if (nev < 256) ev[nev] = 1'b1;
      nev++; nrd++;
    end
    if (wr_valid && wr_ready) begin
      if (nev < 256) ev[nev] = 1'b0;
      if (nwr < 256) begin wa[nwr] = wr_addr; wd[nwr] = wr_data; end
      nev++; nwr++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic cfgw(input logic [2:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic clr();
    nev = 0; nrd = 0; nwr = 0;
  endtask

  task automatic idle_wait(input int lim);
    for (int k = 0; k < lim && busy; k++) begin @(posedge clk); #1; end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [31:0] ctl(input logic en, input logic [1:0] dir, input logic [1:0] sz,
      input logic pinc, input logic minc, input logic dbuf, input logic pflow, input logic [2:0] thr);
    return {20'd0, thr, pflow, dbuf, minc, pinc, sz, dir, en};
  endfunction

  typedef struct packed {
    logic [1:0]  dir;
    logic [1:0]  size;
    logic        pinc;
    logic        minc;
    logic [2:0]  thr;
    logic [15:0] len;
    logic [31:0] par;
    logic [31:0] m0;
    logic        err;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'd0, 2'd2, 1'b0, 1'b1, 3'd2, 16'd5, 32'h4000_0000, 32'h2000_0000, 1'b0},
    '{2'd1, 2'd1, 1'b0, 1'b1, 3'd4, 16'd3, 32'h4000_1002, 32'h2000_0100, 1'b0},
    '{2'd2, 2'd0, 1'b1, 1'b1, 3'd3, 16'd7, 32'h1000_0001, 32'hFFFF_FFF0, 1'b0},
    '{2'd3, 2'd0, 1'b1, 1'b1, 3'd1, 16'd2, 32'h4000_0000, 32'h2000_0000, 1'b1},
    '{2'd0, 2'd2, 1'b0, 1'b1, 3'd1, 16'd2, 32'h4000_0002, 32'h2000_0000, 1'b1},
    '{2'd0, 2'd1, 1'b0, 1'b1, 3'd1, 16'd2, 32'h4000_0000, 32'h2000_0001, 1'b1},
    '{2'd2, 2'd2, 1'b1, 1'b0, 3'd0, 16'd4, 32'hFFFF_FFF0, 32'h0000_0000, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R12: watchdog expired, actual hung expected finished");
    report();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    chk(!busy && !done && !cfg_err && !rd_valid && !wr_valid, "R12",
        {27'd0, busy, done, cfg_err, rd_valid, wr_valid}, 32'd0);

    stall_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      vec_t v;
      int step, te, idx, rem, c, bad_a, bad_d, bad_e;
      logic psrc, si, di;
      logic [31:0] s0, d0, sa, da;
      v = VEC[i];
      cfgw(3'd1, {16'd0, v.len});
      cfgw(3'd2, v.par);
      cfgw(3'd3, v.m0);
      clr();
      preq = 1'b1;
      cfgw(3'd0, ctl(1'b1, v.dir, v.size, v.pinc, v.minc, 1'b0, 1'b0, v.thr));
      // R2 start acceptance
      chk(cfg_err == v.err, "R2", {31'd0, cfg_err}, {31'd0, v.err});
      if (v.err) begin
        tick(4);
        chk(!busy && nrd == 0, "R2", nrd, 32'd0);
      end else begin
        idle_wait(2000);
        preq = 1'b0;
        // R3 count runs out and completion flagged
        chk(done && !busy && nwr == int'(v.len) && items_left == 16'd0, "R3", nwr, {16'd0, v.len});
        step = 1 << v.size;
        psrc = v.dir != 2'd1;
        s0 = psrc ? v.par : v.m0;
        d0 = psrc ? v.m0 : v.par;
        si = psrc ? v.pinc : v.minc;
        di = psrc ? v.minc : v.pinc;
        bad_a = 0; bad_d = 0;
        for (int j = 0; j < int'(v.len); j++) begin
          sa = s0 + 32'(j * step * int'(si));
          da = d0 + 32'(j * step * int'(di));
          if (wa[j] != da) bad_a++;
          if (wd[j] != sa * 32'd3 + 32'h11) bad_d++;
        end
        // R1 routing and data order
        chk(bad_d == 0, "R1", bad_d, 32'd0);
        // R7 address stepping
        chk(bad_a == 0, "R7", bad_a, 32'd0);
        te = (v.thr == 3'd0 || v.thr > 3'd4) ? 4 : int'(v.thr);
        idx = 0; rem = int'(v.len); bad_e = 0;
        while (rem > 0) begin
          c = (rem < te) ? rem : te;
          for (int k = 0; k < c; k++) begin if (ev[idx] != 1'b1) bad_e++; idx++; end
          for (int k = 0; k < c; k++) begin if (ev[idx] != 1'b0) bad_e++; idx++; end
          rem -= c;
        end
        // R6 threshold fill/drain sequence
        chk(bad_e == 0 && nev == idx, "R6", bad_e, 32'd0);
      end
    end

    // R2 zero count refused
    cfgw(3'd1, 32'd0);
    cfgw(3'd0, ctl(1'b1, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1));
    chk(cfg_err && !busy, "R2", {31'd0, cfg_err}, 32'd1);

    // R4 request gating
    cfgw(3'd1, 32'd4);
    cfgw(3'd2, 32'h4000_0000);
    cfgw(3'd3, 32'h2000_0000);
    clr(); preq = 1'b0;
    cfgw(3'd0, ctl(1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1));
    tick(10);
    chk(nrd == 0, "R4", nrd, 32'd0);
    preq = 1'b1; tick(1); preq = 1'b0;
    tick(6);
    chk(nrd == 1 && nwr == 1, "R4", nrd, 32'd1);
    // R9 disable while idle-waiting for requests
    cfgw(3'd0, ctl(1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1));
    idle_wait(100);
    chk(!busy && done && nwr == 1, "R9", nwr, 32'd1);

    // R5 memory-to-memory without requests
    cfgw(3'd1, 32'd6);
    clr();
    cfgw(3'd0, ctl(1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2));
    idle_wait(200);
    chk(done && nwr == 6 && nrd == 6, "R5", nwr, 32'd6);

    // R8 flow-controlled end of transfer
    cfgw(3'd1, 32'd200);
    clr(); preq = 1'b1;
    cfgw(3'd0, ctl(1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4));
    tick(9);
    peot = 1'b1; tick(1); peot = 1'b0;
    idle_wait(200);
    preq = 1'b0;
    chk(done && !busy && nwr == nrd && nrd < 200, "R8", nwr, nrd);
    chk(int'(items_left) == 200 - nwr, "R8", {16'd0, items_left}, 32'(200 - nwr));

    // R8 end-of-transfer ignored without flow control
    cfgw(3'd1, 32'd8);
    clr(); preq = 1'b1;
    cfgw(3'd0, ctl(1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4));
    tick(3);
    peot = 1'b1; tick(1); peot = 1'b0;
    idle_wait(200);
    preq = 1'b0;
    chk(done && nwr == 8, "R8", nwr, 32'd8);

    // R9 software disable mid-transfer flushes FIFO
    cfgw(3'd1, 32'd1000);
    clr();
    cfgw(3'd0, ctl(1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4));
    tick(7);
    cfgw(3'd0, ctl(1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4));
    idle_wait(100);
    chk(done && !busy && nwr == nrd && nrd > 0 && nrd < 1000, "R9", nwr, nrd);

    // R10 double buffer
    cfgw(3'd1, 32'd3);
    cfgw(3'd3, 32'h0000_2000);
    cfgw(3'd4, 32'h0000_3000);
    clr(); preq = 1'b1;
    cfgw(3'd0, ctl(1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4));
    for (int k = 0; k < 500 && nwr < 9; k++) tick(1);
    begin
      int bad_b, w;
      logic [31:0] exp_a;
      bad_b = 0;
      w = nwr;
      for (int j = 0; j < 9; j++) begin
        exp_a = (((j / 3) % 2) == 0 ? 32'h2000 : 32'h3000) + 32'((j % 3) * 4);
        if (wa[j] != exp_a) bad_b++;
      end
      chk(bad_b == 0, "R10", bad_b, 32'd0);
      chk(busy && mem_sel == 1'(((w / 3) % 2)), "R10", {31'd0, mem_sel}, 32'((w / 3) % 2));
      chk(int'(items_left) == 3 - (w % 3), "R10", {16'd0, items_left}, 32'(3 - (w % 3)));
    end
    preq = 1'b0;
    cfgw(3'd0, ctl(1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4));
    idle_wait(100);
    chk(done && !busy && nwr == nrd, "R9", nwr, nrd);

    report();
  end
endmodule